// File: doc/BRIEF.md
# Microthread Fork/Join Scheduler

This block hands out a small pool of hardware thread contexts to microthreads. A fork command carries a start PC, a register snapshot and a spare memory address. If a context is free, the lowest-numbered one is claimed, loaded with the PC and snapshot, and started. If every context is busy, the request is written to memory at the supplied address and appended to a linked list of waiting requests. The hardware keeps only two pointers for that list: its first entry and its last entry.

When a running context exits and requests are waiting, the oldest one is read back from memory and started in the context that just exited. A join command lets one thread wait for a partner thread. When the partner exits, one value from each thread is combined by addition, minimum or maximum, and the result is returned to the waiting thread. Each fork hands the parent an even tag and the child the odd tag that follows it, so the two threads can tell themselves apart.

Top module: `mt_sched`

## Requirements
- R1: After reset no context is active, none is stalled, `cmd_ready` is 1, `mem_req` is 0 and no valid output is raised.
- R2: Each accepted fork takes the next sequence number s, starting at 0 after reset. The parent receives tag 2s on `fork_ack_tag` (bit 0 = 0). The child receives tag 2s+1 (bit 0 = 1) whenever it starts.
- R3: A fork that finds a free context claims the lowest-numbered one. The cycle after acceptance, `start_valid` is raised with that context number, the given PC and snapshot, and the context shows active.
- R4: A fork that finds no free context raises `fork_ack_queued` and starts nothing. It writes the entry {next(AW)=0, tag, pc, regs} (MSB to LSB) to `cmd_addr`.
- R5: A fork queued onto an empty list makes that entry both first and last and does no link write. Otherwise it does one write with `mem_link`=1 to the old last entry, which updates only the next field (top AW bits) to the new address.
- R6: An exit of an active context while entries wait reads the first entry. It starts that entry in the exited context, which stays active, and the first pointer advances to the entry's next field. A next value of 0 means the list is empty.
- R7: An exit of an active context with no waiting entry makes that context inactive.
- R8: An exit naming an inactive context has no effect: no start, no join result, no change to the active mask, and the stored exit value is unchanged.
- R9: A join whose partner is active stalls the waiting context (`ctx_stall` bit set). When the partner exits, `join_valid` is raised the next cycle with `join_ctx` equal to the waiter, and the stall clears.
- R10: Reduction code 1 gives the unsigned minimum and code 2 gives the unsigned maximum. Codes 0 and 3 give the sum modulo 2^DW.
- R11: A join whose partner is inactive completes the cycle after acceptance. It uses the value passed by the partner's most recent exit.
- R12: From the acceptance of a fork that is queued, or of an exit that dequeues, `cmd_ready` stays low until the memory work is done. An outstanding memory request holds its address and direction until `mem_ack`.
- R13: Waiting entries are started in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 fork, 1 exit, 2 join, 3 none |
| cmd_pc | input | PCW | Fork: child start PC |
| cmd_regs | input | RW | Fork: register snapshot |
| cmd_addr | input | AW | Fork: memory address for a queued entry (non-zero) |
| cmd_ctx | input | CW | Exit: exiting context; join: waiting context |
| cmd_partner | input | CW | Join: partner context |
| cmd_red | input | 2 | Join: reduction code |
| cmd_value | input | DW | Exit: thread's result; join: waiter's operand |
| cmd_ready | output | 1 | Command accepted when valid and ready |
| fork_ack_valid | output | 1 | Fork acknowledged |
| fork_ack_tag | output | TW | Parent tag (even) |
| fork_ack_queued | output | 1 | Child was queued |
| start_valid | output | 1 | A context starts |
| start_ctx | output | CW | Context that starts |
| start_pc | output | PCW | Start PC |
| start_regs | output | RW | Register snapshot |
| start_tag | output | TW | Child tag (odd) |
| join_valid | output | 1 | Join result ready |
| join_ctx | output | CW | Thread receiving the result |
| join_value | output | DW | Reduced value |
| ctx_active | output | N | Active context mask |
| ctx_stall | output | N | Contexts stalled in a join |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1 |
| mem_link | output | 1 | Write affects only the next field |
| mem_addr | output | AW | Entry address |
| mem_wdata | output | AW+TW+PCW+RW | Entry data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | AW+TW+PCW+RW | Entry read data |

## Verification
The bench targets the first fork that overflows into an empty list. A design that always links would write to address 0 and corrupt memory. It also checks the second and third overflows. A design that linked from the head instead of the tail would break the chain and start entries out of order.

Exits are checked on the last waiting entry, where a design that failed to clear the tail would later link onto a stale entry. They are also checked on an already-free context, where a careless design would overwrite the stored exit value and give a later join a wrong sum. Every reduction code is exercised, including an addition that wraps, and joins are tested against both a running partner and a partner that has already exited.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    CMD_FORK = 2'd0,
    CMD_EXIT = 2'd1,
    CMD_JOIN = 2'd2,
    CMD_NONE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    RED_ADD = 2'd0,
    RED_MIN = 2'd1,
    RED_MAX = 2'd2,
    RED_SUM = 2'd3
  } red_e;

  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_WRITE = 2'd1,
    Q_LINK  = 2'd2,
    Q_READ  = 2'd3
  } qst_e;
endpackage

// File: rtl/mt_prio_enc.sv
module mt_prio_enc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mt_join_reduce.sv
module mt_join_reduce import mt_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    op,
  output logic [DW-1:0] y
);
  red_e sel;
  assign sel = red_e'(op);

  always_comb begin
    case (sel)
      RED_MIN: y = (a < b) ? a : b;
      RED_MAX: y = (a > b) ? a : b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mt_queue_ctl.sv
module mt_queue_ctl import mt_pkg::*; #(
  parameter int AW = 16,
  parameter int PW = 56,
  localparam int EW = AW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_go,
  input  logic [AW-1:0] enq_addr,
  input  logic [PW-1:0] enq_payload,
  input  logic          deq_go,
  output logic          idle,
  output logic          empty,
  output logic          deq_done,
  output logic [PW-1:0] deq_payload,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_link,
  output logic [AW-1:0] mem_addr,
  output logic [EW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [EW-1:0] mem_rdata
);
  qst_e          state;
  logic [AW-1:0] head, tail, new_addr;
  logic [AW-1:0] rd_next;

  assign idle    = (state == Q_IDLE);
  assign empty   = (head == '0);
  assign rd_next = mem_rdata[EW-1:PW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= Q_IDLE;
      head        <= '0;
      tail        <= '0;
      new_addr    <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_link    <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      deq_done    <= 1'b0;
      deq_payload <= '0;
    end else begin
      deq_done <= 1'b0;
      case (state)
        Q_IDLE: begin
          if (enq_go) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_link  <= 1'b0;
            mem_addr  <= enq_addr;
            mem_wdata <= {{AW{1'b0}}, enq_payload};
            new_addr  <= enq_addr;
            state     <= Q_WRITE;
          end else if (deq_go) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_link <= 1'b0;
            mem_addr <= head;
            state    <= Q_READ;
          end
        end
        Q_WRITE: begin
          if (mem_ack) begin
            if (head == '0) begin
              head    <= new_addr;
              tail    <= new_addr;
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              state   <= Q_IDLE;
            end else begin
              mem_link  <= 1'b1;
              mem_addr  <= tail;
              mem_wdata <= {new_addr, {PW{1'b0}}};
              state     <= Q_LINK;
            end
          end
        end
        Q_LINK: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            mem_link <= 1'b0;
            tail     <= new_addr;
            state    <= Q_IDLE;
          end
        end
        default: begin
          if (mem_ack) begin
            mem_req     <= 1'b0;
            deq_done    <= 1'b1;
            deq_payload <= mem_rdata[PW-1:0];
            head        <= rd_next;
            if (rd_next == '0) tail <= '0;
            state       <= Q_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mt_sched.sv
module mt_sched import mt_pkg::*; #(
  parameter int N   = 4,
  parameter int AW  = 16,
  parameter int PCW = 16,
  parameter int RW  = 32,
  parameter int DW  = 16,
  parameter int TW  = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = TW + PCW + RW,
  localparam int EW = AW + PW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [PCW-1:0] cmd_pc,
  input  logic [RW-1:0]  cmd_regs,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [CW-1:0]  cmd_ctx,
  input  logic [CW-1:0]  cmd_partner,
  input  logic [1:0]     cmd_red,
  input  logic [DW-1:0]  cmd_value,
  output logic           cmd_ready,
  output logic           fork_ack_valid,
  output logic [TW-1:0]  fork_ack_tag,
  output logic           fork_ack_queued,
  output logic           start_valid,
  output logic [CW-1:0]  start_ctx,
  output logic [PCW-1:0] start_pc,
  output logic [RW-1:0]  start_regs,
  output logic [TW-1:0]  start_tag,
  output logic           join_valid,
  output logic [CW-1:0]  join_ctx,
  output logic [DW-1:0]  join_value,
  output logic [N-1:0]   ctx_active,
  output logic [N-1:0]   ctx_stall,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_link,
  output logic [AW-1:0]  mem_addr,
  output logic [EW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [EW-1:0]  mem_rdata
);
  logic [N-1:0]          active, jwait, hit;
  logic [N-1:0][CW-1:0]  jpartner;
  logic [N-1:0][1:0]     jop;
  logic [N-1:0][DW-1:0]  jval, retval;
  logic [TW-2:0]         seq;
  logic [CW-1:0]         deq_ctx;

  logic                  accept, ctx_live, partner_live;
  logic                  free_found, hit_found;
  logic [CW-1:0]         free_idx, hit_idx;
  logic                  q_idle, q_empty, deq_done, enq_go, deq_go;
  logic [PW-1:0]         deq_payload;
  logic [DW-1:0]         red_a, red_b, red_y;
  logic [1:0]            red_op;
  cmd_e                  op;

  assign op           = cmd_e'(cmd_op);
  assign cmd_ready    = q_idle && !deq_done;
  assign accept       = cmd_valid && cmd_ready;
  assign ctx_live     = active[cmd_ctx];
  assign partner_live = active[cmd_partner];
  assign enq_go       = accept && (op == CMD_FORK) && !free_found;
  assign deq_go       = accept && (op == CMD_EXIT) && ctx_live && !q_empty;
  assign ctx_active   = active;
  assign ctx_stall    = jwait;

  always_comb begin
    for (int i = 0; i < N; i++) hit[i] = jwait[i] && (jpartner[i] == cmd_ctx);
  end

  mt_prio_enc #(.N(N), .IW(CW)) u_free (.req(~active), .found(free_found), .idx(free_idx));
  mt_prio_enc #(.N(N), .IW(CW)) u_hit  (.req(hit),     .found(hit_found),  .idx(hit_idx));

  always_comb begin
    if (op == CMD_EXIT) begin
      red_a  = jval[hit_idx];
      red_b  = cmd_value;
      red_op = jop[hit_idx];
    end else begin
      red_a  = cmd_value;
      red_b  = retval[cmd_partner];
      red_op = cmd_red;
    end
  end

  mt_join_reduce #(.DW(DW)) u_red (.a(red_a), .b(red_b), .op(red_op), .y(red_y));

  mt_queue_ctl #(.AW(AW), .PW(PW)) u_queue (
    .clk(clk), .rst(rst),
    .enq_go(enq_go), .enq_addr(cmd_addr),
    .enq_payload({seq, 1'b1, cmd_pc, cmd_regs}),
    .deq_go(deq_go), .idle(q_idle), .empty(q_empty),
    .deq_done(deq_done), .deq_payload(deq_payload),
    .mem_req(mem_req), .mem_we(mem_we), .mem_link(mem_link),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active          <= '0;
      jwait           <= '0;
      jpartner        <= '0;
      jop             <= '0;
      jval            <= '0;
      retval          <= '0;
      seq             <= '0;
      deq_ctx         <= '0;
      fork_ack_valid  <= 1'b0;
      fork_ack_tag    <= '0;
      fork_ack_queued <= 1'b0;
      start_valid     <= 1'b0;
      start_ctx       <= '0;
      start_pc        <= '0;
      start_regs      <= '0;
      start_tag       <= '0;
      join_valid      <= 1'b0;
      join_ctx        <= '0;
      join_value      <= '0;
    end else begin
      fork_ack_valid <= 1'b0;
      start_valid    <= 1'b0;
      join_valid     <= 1'b0;
      if (deq_done) begin
        start_valid                        <= 1'b1;
        start_ctx                          <= deq_ctx;
        {start_tag, start_pc, start_regs}  <= deq_payload;
      end
      if (accept) begin
        case (op)
          CMD_FORK: begin
            fork_ack_valid  <= 1'b1;
            fork_ack_tag    <= {seq, 1'b0};
            fork_ack_queued <= !free_found;
            seq             <= seq + 1'b1;
            if (free_found) begin
              active[free_idx] <= 1'b1;
              start_valid      <= 1'b1;
              start_ctx        <= free_idx;
              start_pc         <= cmd_pc;
              start_regs       <= cmd_regs;
              start_tag        <= {seq, 1'b1};
            end
          end
          CMD_EXIT: begin
            if (ctx_live) begin
              retval[cmd_ctx] <= cmd_value;
              if (q_empty) active[cmd_ctx] <= 1'b0;
              else         deq_ctx         <= cmd_ctx;
              if (hit_found) begin
                join_valid     <= 1'b1;
                join_ctx       <= hit_idx;
                join_value     <= red_y;
                jwait[hit_idx] <= 1'b0;
              end
            end
          end
          CMD_JOIN: begin
            if (partner_live) begin
              jwait[cmd_ctx]    <= 1'b1;
              jpartner[cmd_ctx] <= cmd_partner;
              jop[cmd_ctx]      <= cmd_red;
              jval[cmd_ctx]     <= cmd_value;
            end else begin
              join_valid <= 1'b1;
              join_ctx   <= cmd_ctx;
              join_value <= red_y;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mt_sched_chk.sv
module mt_sched_chk #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int TW = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          fork_ack_valid,
  input logic [TW-1:0] fork_ack_tag,
  input logic          fork_ack_queued,
  input logic          start_valid,
  input logic [CW-1:0] start_ctx,
  input logic [TW-1:0] start_tag,
  input logic          join_valid,
  input logic [CW-1:0] join_ctx,
  input logic [N-1:0]  ctx_active,
  input logic [N-1:0]  ctx_stall,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  a_r2_child_tag_odd: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> start_tag[0]);

  a_r2_parent_tag_even: assert property (@(posedge clk) disable iff (rst)
    fork_ack_valid |-> !fork_ack_tag[0]);

  a_r3_started_ctx_active: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> ctx_active[start_ctx]);

  a_r4_queued_no_start: assert property (@(posedge clk) disable iff (rst)
    (fork_ack_valid && fork_ack_queued) |-> !start_valid);

  a_r9_stall_cleared_on_result: assert property (@(posedge clk) disable iff (rst)
    join_valid |-> !ctx_stall[join_ctx]);

  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_busy_during_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready);
endmodule

bind mt_sched mt_sched_chk #(.N(N), .AW(AW), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready),
  .fork_ack_valid(fork_ack_valid), .fork_ack_tag(fork_ack_tag),
  .fork_ack_queued(fork_ack_queued), .start_valid(start_valid),
  .start_ctx(start_ctx), .start_tag(start_tag), .join_valid(join_valid),
  .join_ctx(join_ctx), .ctx_active(ctx_active), .ctx_stall(ctx_stall),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/tb_mt_sched.sv
`timescale 1ns/1ps
module tb_mt_sched;
  localparam int N = 4, AW = 16, PCW = 16, RW = 32, DW = 16, TW = 8;
  localparam int CW = 2, PW = TW + PCW + RW, EW = AW + PW;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic cmd_valid = 0;
  logic [1:0] cmd_op = 3, cmd_red = 0;
  logic [PCW-1:0] cmd_pc = 0;
  logic [RW-1:0] cmd_regs = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [CW-1:0] cmd_ctx = 0, cmd_partner = 0;
  logic [DW-1:0] cmd_value = 0;
  logic cmd_ready, fork_ack_valid, fork_ack_queued, start_valid, join_valid;
  logic [TW-1:0] fork_ack_tag, start_tag;
  logic [CW-1:0] start_ctx, join_ctx;
  logic [PCW-1:0] start_pc;
  logic [RW-1:0] start_regs;
  logic [DW-1:0] join_value;
  logic [N-1:0] ctx_active, ctx_stall;
  logic mem_req, mem_we, mem_link, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [EW-1:0] mem_wdata, mem_rdata = 0;

  mt_sched dut (.*);

  int compared = 0, mismatched = 0;
  bit finished = 0, settled = 0;

  // bench memory: ack one cycle after a request is seen
  logic [EW-1:0] mem [int];
  int dly = 0, n_link = 0;
  logic [AW-1:0] link_addr;
  always @(negedge clk) begin
    if (rst) begin mem_ack = 0; dly = 0; end
    else if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (dly < 1) dly++;
      else begin
        dly = 0; mem_ack = 1;
        if (mem_we) begin
          if (mem_link) begin
            logic [EW-1:0] t;
            t = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
            t[EW-1:PW] = mem_wdata[EW-1:PW];
            mem[int'(mem_addr)] = t;
            n_link++; link_addr = mem_addr;
          end else mem[int'(mem_addr)] = mem_wdata;
        end else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
      end
    end
  end

  // output monitor
  int n_start = 0, n_join = 0, n_ack = 0;
  logic [CW-1:0] o_sctx, o_jctx;
  logic [PW-1:0] o_spay;
  logic [DW-1:0] o_jval;
  logic [TW-1:0] o_atag;
  logic o_aq;

  // reference model
  bit [N-1:0] m_active = 0;
  int m_seq = 0;
  typedef struct { logic [AW-1:0] addr; logic [PW-1:0] pay; } ent_t;
  ent_t m_q[$];
  logic [DW-1:0] m_ret [N];
  int m_wp [N];
  logic [1:0] m_wop [N];
  logic [DW-1:0] m_wv [N];

  function automatic logic [N-1:0] m_stall();
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++) s[i] = (m_wp[i] >= 0);
    return s;
  endfunction

  function automatic logic [DW-1:0] m_red(logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] op);
    if (op == 2'd1) return (a < b) ? a : b;
    if (op == 2'd2) return (a > b) ? a : b;
    return DW'(int'(a) + int'(b));
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (start_valid) begin n_start++; o_sctx = start_ctx; o_spay = {start_tag, start_pc, start_regs}; end
      if (join_valid) begin n_join++; o_jctx = join_ctx; o_jval = join_value; end
      if (fork_ack_valid) begin n_ack++; o_atag = fork_ack_tag; o_aq = fork_ack_queued; end
      if (settled) begin
        chk("R3 R7", "active mask", 128'(ctx_active), 128'(m_active));
        chk("R9", "stall mask", 128'(ctx_stall), 128'(m_stall()));
      end
    end
  end

  bit busy_seen;
  task automatic issue(logic [1:0] op, logic [PCW-1:0] pc, logic [RW-1:0] regs, logic [AW-1:0] addr,
                       logic [CW-1:0] c, logic [CW-1:0] p, logic [1:0] red, logic [DW-1:0] v);
    settled = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    n_start = 0; n_join = 0; n_ack = 0; n_link = 0;
    cmd_valid = 1; cmd_op = op; cmd_pc = pc; cmd_regs = regs; cmd_addr = addr;
    cmd_ctx = c; cmd_partner = p; cmd_red = red; cmd_value = v;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 3;
    busy_seen = !cmd_ready;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    settled = 1;
  endtask

  task automatic do_fork(logic [PCW-1:0] pc, logic [RW-1:0] regs, logic [AW-1:0] addr);
    int fi = -1;
    logic [TW-1:0] ptag = TW'(m_seq * 2);
    logic [PW-1:0] pay = {TW'(m_seq * 2 + 1), pc, regs};
    int old_len = m_q.size();
    logic [AW-1:0] old_tail = (old_len > 0) ? m_q[old_len - 1].addr : '0;
    for (int i = 0; i < N; i++) if (!m_active[i] && fi < 0) fi = i;
    if (fi >= 0) m_active[fi] = 1;
    issue(2'd0, pc, regs, addr, 0, 0, 0, 0);
    chk("R2", "ack count", 128'(n_ack), 128'(1));
    chk("R2", "parent tag", 128'(o_atag), 128'(ptag));
    chk("R4", "queued flag", 128'(o_aq), 128'(fi < 0));
    if (fi >= 0) begin
      chk("R3", "start count", 128'(n_start), 128'(1));
      chk("R3", "start ctx", 128'(o_sctx), 128'(fi));
      chk("R2 R3", "start tag/pc/regs", 128'(o_spay), 128'(pay));
    end else begin
      chk("R4", "no start", 128'(n_start), 128'(0));
      chk("R4", "entry in memory", 128'(mem[int'(addr)]), 128'({{AW{1'b0}}, pay}));
      chk("R12", "busy while queuing", 128'(busy_seen), 128'(1));
      chk("R5", "link writes", 128'(n_link), 128'(old_len > 0));
      if (old_len > 0) begin
        chk("R5", "link address", 128'(link_addr), 128'(old_tail));
        chk("R5", "old tail next", 128'(mem[int'(old_tail)][EW-1:PW]), 128'(addr));
      end
      m_q.push_back('{addr, pay});
    end
    m_seq++;
  endtask

  task automatic do_exit(int c, logic [DW-1:0] v);
    int w = -1;
    bit deq = 0;
    ent_t e;
    logic [DW-1:0] jexp = '0;
    if (!m_active[c]) begin
      issue(2'd1, 0, 0, 0, CW'(c), 0, 0, v);
      chk("R8", "no start", 128'(n_start), 128'(0));
      chk("R8", "no join", 128'(n_join), 128'(0));
      chk("R8", "active unchanged", 128'(ctx_active), 128'(m_active));
      return;
    end
    m_ret[c] = v;
    for (int i = N - 1; i >= 0; i--) if (m_wp[i] == c) w = i;
    if (w >= 0) begin jexp = m_red(m_wv[w], v, m_wop[w]); m_wp[w] = -1; end
    if (m_q.size() > 0) begin e = m_q.pop_front(); deq = 1; end
    else m_active[c] = 0;
    issue(2'd1, 0, 0, 0, CW'(c), 0, 0, v);
    chk("R9", "join count", 128'(n_join), 128'(w >= 0));
    if (w >= 0) begin
      chk("R9", "join ctx", 128'(o_jctx), 128'(w));
      chk("R10", "join value", 128'(o_jval), 128'(jexp));
    end
    if (deq) begin
      chk("R12", "busy while dequeuing", 128'(busy_seen), 128'(1));
      chk("R6", "start count", 128'(n_start), 128'(1));
      chk("R6", "start in exited ctx", 128'(o_sctx), 128'(c));
      chk("R13", "oldest entry started", 128'(o_spay), 128'(e.pay));
    end else chk("R7", "no start", 128'(n_start), 128'(0));
  endtask

  task automatic do_join(int w, int p, logic [1:0] op, logic [DW-1:0] v);
    if (m_active[p]) begin
      m_wp[w] = p; m_wop[w] = op; m_wv[w] = v;
      issue(2'd2, 0, 0, 0, CW'(w), CW'(p), op, v);
      chk("R9", "no early result", 128'(n_join), 128'(0));
      chk("R9", "waiter stalled", 128'(ctx_stall), 128'(m_stall()));
    end else begin
      issue(2'd2, 0, 0, 0, CW'(w), CW'(p), op, v);
      chk("R11", "join count", 128'(n_join), 128'(1));
      chk("R11", "join ctx", 128'(o_jctx), 128'(w));
      chk("R10 R11", "join value", 128'(o_jval), 128'(m_red(v, m_ret[p], op)));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_ret[i] = '0; m_wp[i] = -1; m_wop[i] = 0; m_wv[i] = 0; end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "ready", 128'(cmd_ready), 128'(1));
    chk("R1", "active", 128'(ctx_active), 128'(0));
    chk("R1", "stall", 128'(ctx_stall), 128'(0));
    chk("R1", "mem_req", 128'(mem_req), 128'(0));
    chk("R1", "valids", 128'({start_valid, join_valid, fork_ack_valid}), 128'(0));
    settled = 1;

    do_fork(16'h1000, 32'hA000_0000, 16'h0);
    do_fork(16'h1100, 32'hA000_0011, 16'h0);
    do_fork(16'h1200, 32'hA000_0022, 16'h0);
    do_fork(16'h1300, 32'hA000_0033, 16'h0);
    do_fork(16'h2000, 32'hB000_0001, 16'h0100);
    do_fork(16'h2100, 32'hB000_0002, 16'h0200);
    do_fork(16'h2200, 32'hB000_0003, 16'h0300);

    do_join(0, 2, 2'd1, 16'd50);
    do_exit(2, 16'd30);
    do_exit(1, 16'd7);
    do_exit(3, 16'd5);
    do_exit(3, 16'd9);
    do_exit(3, 16'd1);
    do_join(0, 3, 2'd0, 16'hFFFA);
    do_join(1, 0, 2'd2, 16'd10);
    do_exit(0, 16'd200);
    do_join(2, 1, 2'd2, 16'd500);
    do_exit(1, 16'd40);

    do_fork(16'h3000, 32'hC000_0001, 16'h0);
    do_fork(16'h3100, 32'hC000_0002, 16'h0);
    do_fork(16'h3200, 32'hC000_0003, 16'h0);
    do_fork(16'h3300, 32'hC000_0004, 16'h0400);
    do_exit(2, 16'd0);
    do_join(3, 1, 2'd3, 16'd4);
    do_exit(1, 16'd6);

    summary();
    $finish;
  end
endmodule